// File: doc/BRIEF.md
# Buffered Dual-Pin PWM Channel

This block generates one pulse-width-modulated waveform for motor control. A free-running counter climbs one step per enabled clock and returns to zero when it equals a programmable cycle value, so a period lasts cycle + 1 enabled clocks. The waveform is active from the count-zero point of each period until the counter reaches the active duty value, and inactive for the rest of the period.

Software writes a staging word through a small write port. The word holds a duty value and a pin-select bit. The staged word is copied into the working duty and select registers only at the cycle match, so a write never cuts a period short or stretches it. The select bit sends the waveform to one of two pins. The other pin rests at its inactive level. Each pin has its own polarity bit, which swaps that pin's active and inactive levels.

Register map (`wr_addr_i`):
- 0: staging word. Bit 12 is the pin select and bits CNT_W-1:0 are the duty.
- 1: cycle value, in bits CNT_W-1:0.
- 2: polarity. Bit 0 is pin A and bit 1 is pin B.

CNT_W must be at most 10, so that the duty field stays clear of the select bit.

Top module: `pwm_steer_chan`

## Requirements
- R1: After the synchronous reset, every register is zero and both pins are low. With no register writes, both pins stay low even while the counter runs.
- R2: The counter advances by one on each clock where `run_en_i` is high. It holds its value while `run_en_i` is low, and the pin levels hold with it.
- R3: When the counter equals the cycle value on an enabled clock, it clears to 0. Each period therefore lasts cycle + 1 enabled clocks and repeats.
- R4: A write to the staging word changes neither the working duty nor the working select until the next cycle match. From that match onward, the new values are in use.
- R5: When the duty value d is at most the cycle value, the selected pin is active at counts 0 to d-1, for exactly d clocks of each period.
- R6: A duty value of 0 gives no active clock at all in the period.
- R7: A duty value greater than the cycle value keeps the selected pin active for the whole period.
- R8: The unselected pin holds its inactive level throughout.
- R9: The active level is 1 and the inactive level 0 when the pin's polarity bit is 0. A polarity bit of 1 swaps both levels for that pin only.
- R10: In the staging word, bit 12 = 0 selects pin A and bit 12 = 1 selects pin B. The duty value is taken from bits CNT_W-1:0. All other bits of the word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Counter step enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 staging word, 1 cycle, 2 polarity |
| wr_data_i | input | 16 | Write data |
| pin_a_o | output | 1 | Output pin A |
| pin_b_o | output | 1 | Output pin B |

## Verification
The bench builds the channel with CNT_W = 4. With that width, every pairing of cycle value and duty value (16 × 16) can be swept in full, and the active clocks of a whole period can be counted against min(d, cycle + 1). The select and polarity settings rotate across the sweep, so the idle-pin and level-swap behaviour is covered for every combination of pin and polarity. Separate scenarios stall the counter mid-period, rewrite the staging word mid-period, and set the ignored bits of the staging word.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    localparam int WORD_W  = 16;
    localparam int SEL_POS = 12;
    localparam int N_PINS  = 2;

    typedef enum logic [1:0] {
        ADDR_STAGE = 2'd0,
        ADDR_CYCLE = 2'd1,
        ADDR_POL   = 2'd2
    } reg_addr_e;

    typedef enum logic {
        PIN_A = 1'b0,
        PIN_B = 1'b1
    } pin_sel_e;

    // Drive level of a pin from its logical activity and polarity bit
    function automatic logic pin_level(input logic active, input logic invert);
        return active ^ invert;
    endfunction

endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        wr_en_i,
    input  logic [1:0]                  wr_addr_i,
    input  logic [WORD_W-1:0]           wr_data_i,
    output logic [CNT_W-1:0]            stage_duty_o,
    output pin_sel_e                    stage_sel_o,
    output logic [CNT_W-1:0]            cycle_o,
    output logic [N_PINS-1:0]           pol_o
);

    logic [CNT_W-1:0]  duty_q;
    pin_sel_e          sel_q;
    logic [CNT_W-1:0]  cycle_q;
    logic [N_PINS-1:0] pol_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            duty_q  <= '0;
            sel_q   <= PIN_A;
            cycle_q <= '0;
            pol_q   <= '0;
        end else if (wr_en_i) begin
            unique case (reg_addr_e'(wr_addr_i))
                ADDR_STAGE: begin
                    duty_q <= wr_data_i[CNT_W-1:0];
                    sel_q  <= pin_sel_e'(wr_data_i[SEL_POS]);
                end
                ADDR_CYCLE: cycle_q <= wr_data_i[CNT_W-1:0];
                ADDR_POL:   pol_q   <= wr_data_i[N_PINS-1:0];
                default: ;
            endcase
        end
    end

    // Bits that no register keeps
    logic unused_bits;
    assign unused_bits = ^{wr_data_i[WORD_W-1:SEL_POS+1], wr_data_i[SEL_POS-1:CNT_W]};

    assign stage_duty_o = duty_q;
    assign stage_sel_o  = sel_q;
    assign cycle_o      = cycle_q;
    assign pol_o        = pol_q;

endmodule

// File: rtl/pwm_cyc_counter.sv
module pwm_cyc_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_en_i,
    input  logic [CNT_W-1:0] cycle_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cyc_hit_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = run_en_i && (cnt_q == cycle_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= '0;
        end else if (run_en_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt_o     = cnt_q;
    assign cyc_hit_o = hit;

    p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_en_i |=> $stable(cnt_q));

    p_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_en_i && cnt_q != cycle_i) |=> (cnt_q == $past(cnt_q) + ONE));

    p_wrap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_en_i && cnt_q == cycle_i) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] stage_duty_i,
    input  pin_sel_e         stage_sel_i,
    output logic [CNT_W-1:0] duty_o,
    output pin_sel_e         sel_o
);

    typedef struct packed {
        pin_sel_e         sel;
        logic [CNT_W-1:0] duty;
    } work_t;

    work_t work_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            work_q <= '0;
        end else if (load_i) begin
            work_q.duty <= stage_duty_i;
            work_q.sel  <= stage_sel_i;
        end
    end

    assign duty_o = work_q.duty;
    assign sel_o  = work_q.sel;

    p_quiet_between_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> ($stable(work_q.duty) && $stable(work_q.sel)));

    p_take_stage_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (work_q.duty == $past(stage_duty_i) && work_q.sel == $past(stage_sel_i)));

endmodule

// File: rtl/pwm_pin_steer.sv
module pwm_pin_steer
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  pin_sel_e          sel_i,
    input  logic [N_PINS-1:0] pol_i,
    output logic [N_PINS-1:0] pins_o
);

    logic wave;

    // Active from count 0 until the counter reaches the duty value
    assign wave = (cnt_i < duty_i);

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        assign pins_o[p] = (sel_i == pin_sel_e'(p)) ? pin_level(wave, pol_i[p])
                                                    : pin_level(1'b0, pol_i[p]);
    end

    p_idle_b_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == PIN_A) |-> (pins_o[1] == pol_i[1]));

    p_idle_a_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == PIN_B) |-> (pins_o[0] == pol_i[0]));

    p_zero_duty_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (duty_i == '0) |-> (pins_o == pol_i));

endmodule

// File: rtl/pwm_steer_chan.sv
module pwm_steer_chan
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_en_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              pin_a_o,
    output logic              pin_b_o
);

    logic [CNT_W-1:0]  stage_duty;
    pin_sel_e          stage_sel;
    logic [CNT_W-1:0]  cycle;
    logic [N_PINS-1:0] pol;
    logic [CNT_W-1:0]  cnt;
    logic              cyc_hit;
    logic [CNT_W-1:0]  duty_act;
    pin_sel_e          sel_act;
    logic [N_PINS-1:0] pins;

    pwm_reg_bank #(.CNT_W(CNT_W)) u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .stage_duty_o (stage_duty),
        .stage_sel_o  (stage_sel),
        .cycle_o      (cycle),
        .pol_o        (pol)
    );

    pwm_cyc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_en_i  (run_en_i),
        .cycle_i   (cycle),
        .cnt_o     (cnt),
        .cyc_hit_o (cyc_hit)
    );

    pwm_duty_latch #(.CNT_W(CNT_W)) u_latch (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .load_i       (cyc_hit),
        .stage_duty_i (stage_duty),
        .stage_sel_i  (stage_sel),
        .duty_o       (duty_act),
        .sel_o        (sel_act)
    );

    pwm_pin_steer #(.CNT_W(CNT_W)) u_steer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cnt_i  (cnt),
        .duty_i (duty_act),
        .sel_i  (sel_act),
        .pol_i  (pol),
        .pins_o (pins)
    );

    assign pin_a_o = pins[0];
    assign pin_b_o = pins[1];

    // Both pins rest low after reset until software programs the channel
    p_reset_low_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!pin_a_o && !pin_b_o));

endmodule

// File: tb/pwm_steer_chan_tb_top.sv
module pwm_steer_chan_tb_top;

    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pin_a;
    logic        pin_b;

    int checks = 0;
    int errors = 0;
    logic [1:0] pol_cur = 2'b00;

    always #5 clk = ~clk;

    pwm_steer_chan #(.CNT_W(CW)) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .run_en_i  (run_en),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .pin_a_o   (pin_a),
        .pin_b_o   (pin_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        run_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Program, start, and run until the first cycle match has loaded the word
    task automatic setup(input int cyc, input logic [15:0] word, input logic [1:0] pol);
        do_reset();
        pol_cur = pol;
        wr(2'd1, 16'(cyc));
        wr(2'd2, {14'd0, pol});
        wr(2'd0, word);
        @(negedge clk);
        run_en = 1'b1;
        repeat (cyc + 1) @(posedge clk);
    endtask

    // Count active samples on each pin over n counter steps
    task automatic measure(input int n, output int ca, output int cb);
        ca = 0;
        cb = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            ca += int'(pin_a ^ pol_cur[0]);
            cb += int'(pin_b ^ pol_cur[1]);
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ca, cb, ea, eb, exp_n;
        logic s;
        logic [1:0] p;

        // R1: reset state, then running with nothing programmed
        do_reset();
        @(negedge clk);
        chk("R1 pin_a after reset", int'(pin_a), 0);
        chk("R1 pin_b after reset", int'(pin_b), 0);
        run_en = 1'b1;
        pol_cur = 2'b00;
        measure(20, ca, cb);
        chk("R1 pin_a idle while running unprogrammed", ca, 0);
        chk("R1 pin_b idle while running unprogrammed", cb, 0);

        // R5 R6 R7 R8 R9 R10 R3: full sweep of cycle x duty
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 16; d++) begin
                s = 1'((c + d) & 1);
                p = 2'((c * 3 + d) % 4);
                setup(c, {3'b000, s, 8'd0, 4'(d)}, p);
                measure(c + 1, ca, cb);
                exp_n = (d < c + 1) ? d : c + 1;
                ea = (s == 1'b0) ? exp_n : 0;
                eb = (s == 1'b1) ? exp_n : 0;
                if (d == 0) begin
                    chk($sformatf("R6 c=%0d d=%0d pin_a", c, d), ca, ea);
                    chk($sformatf("R6 c=%0d d=%0d pin_b", c, d), cb, eb);
                end else if (d > c) begin
                    chk($sformatf("R7 c=%0d d=%0d sel=%0d pin_a", c, d, s), ca, ea);
                    chk($sformatf("R7 c=%0d d=%0d sel=%0d pin_b", c, d, s), cb, eb);
                end else begin
                    chk($sformatf("R5 R8 R9 c=%0d d=%0d sel=%0d pol=%0d pin_a", c, d, s, p), ca, ea);
                    chk($sformatf("R5 R8 R9 c=%0d d=%0d sel=%0d pol=%0d pin_b", c, d, s, p), cb, eb);
                end
                // R3: next period begins again at count 0
                @(negedge clk);
                chk($sformatf("R3 restart c=%0d d=%0d", c, d),
                    int'((s ? pin_b ^ p[1] : pin_a ^ p[0])), (d > 0) ? 1 : 0);
            end
        end

        // R9: both polarity bits set, duty 0 -> both pins sit high
        setup(5, 16'h0000, 2'b11);
        @(negedge clk);
        chk("R9 pin_a inverted idle level", int'(pin_a), 1);
        chk("R9 pin_b inverted idle level", int'(pin_b), 1);

        // R2: stall the counter inside the active window
        setup(15, 16'h0005, 2'b00);
        repeat (3) begin
            @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        run_en = 1'b0;
        ca = 0;
        repeat (10) begin
            @(posedge clk);
            @(negedge clk);
            ca += int'(pin_a);
        end
        chk("R2 pin_a holds active while stalled", ca, 10);
        run_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 pin_a active at count 4", int'(pin_a), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R2 pin_a inactive at count 5", int'(pin_a), 0);

        // R4: rewrite the staging word mid-period
        setup(9, 16'h0005, 2'b00);
        ca = 0;
        cb = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (j == 1) begin
                wr_en = 1'b1;
                wr_addr = 2'd0;
                wr_data = 16'h1008;
            end
            if (j == 2) wr_en = 1'b0;
            ca += int'(pin_a);
            cb += int'(pin_b);
            @(posedge clk);
        end
        chk("R4 current period keeps old duty on pin_a", ca, 5);
        chk("R4 current period keeps pin_b idle", cb, 0);
        measure(10, ca, cb);
        chk("R4 next period pin_a idle", ca, 0);
        chk("R4 next period pin_b takes new duty", cb, 8);

        // R10: ignored bits set around the fields
        setup(7, 16'hEFF3, 2'b00);
        measure(8, ca, cb);
        chk("R10 ignored bits, pin_a duty 3", ca, 3);
        chk("R10 ignored bits, pin_b idle", cb, 0);
        setup(7, 16'hFFF2, 2'b00);
        measure(8, ca, cb);
        chk("R10 select bit high, pin_a idle", ca, 0);
        chk("R10 select bit high, pin_b duty 2", cb, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule